// File: doc/BRIEF.md
# Turf-based memory protection region checker

This block decides, ahead of the caches, whether a memory access may proceed. It holds a small table of address ranges. Each range has its own permissions and belongs to an owner: either a protection domain ("turf") or, when the entry is wildcarded, a single thread. Protection is kept apart from address translation. The checker sees only the access address, the kind of access, and the current turf and thread identifiers. The turf identifier comes from a register outside this block that changes on protected cross-domain calls.

Every entry is compared with the request in parallel. An entry grants the access when all of the following hold:
- it is valid;
- its owner applies to the request;
- its range covers the address;
- it carries the permission bit that the access kind needs.

The lowest-numbered granting entry wins, and its index is reported. When no entry grants the access, a one-cycle fault pulse comes out instead. A simple write port loads or invalidates one entry per cycle.

Top module: `prot_region_chk`

## Requirements
- R1: After reset every entry is invalid, so any request faults until entries are written.
- R2: An entry covers an address `a` only when `lo <= a < hi` (unsigned, upper bound exclusive). An entry with `lo >= hi` covers nothing.
- R3: A non-wildcard entry applies only when its owner field equals `cur_turf`. `cur_thread` is ignored for such entries.
- R4: A wildcard entry applies only when its owner field equals `cur_thread`. `cur_turf` is ignored for such entries.
- R5: Access kinds are encoded as follows: `req_kind` 0 = data read, 1 = data write, 2 = code execute, 3 = portal call. Kind k requires bit k of the entry's 4-bit permission field.
- R6: Among all granting entries, the lowest index is reported in `rsp_idx`. An entry that covers and applies but lacks the needed permission is skipped.
- R7: A request in cycle n produces `rsp_valid` in cycle n+1, together with exactly one of `rsp_grant` or `rsp_fault`. On a fault, `rsp_idx` is 0.
- R8: A configuration write takes effect from the next cycle. A request made in the same cycle as a write is checked against the table as it stood before the write.
- R9: An entry written with `cfg_valid` = 0 never grants, whatever its other fields hold.
- R10: In a cycle after no request, `rsp_valid`, `rsp_grant`, `rsp_fault` and `rsp_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write one table entry this cycle |
| cfg_idx | input | IDX_W (4) | Entry to write |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_wild | input | 1 | Owner field is a thread ID rather than a turf ID |
| cfg_perm | input | 4 | Permissions: bit0 read, bit1 write, bit2 execute, bit3 portal |
| cfg_owner | input | ID_W (16) | Owning turf or thread ID |
| cfg_lo | input | ADDR_W (64) | Inclusive lower bound |
| cfg_hi | input | ADDR_W (64) | Exclusive upper bound |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | Access kind (see R5) |
| req_addr | input | ADDR_W (64) | Access address |
| cur_turf | input | ID_W (16) | Current turf ID |
| cur_thread | input | ID_W (16) | Current thread ID |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused (one-cycle pulse) |
| rsp_idx | output | IDX_W (4) | Index of the granting entry, 0 on fault |

## Verification
Wrong internal state shows up at the ports on the very next request that touches it. A lost valid bit, a corrupted bound or owner, or a swapped permission bit shows one cycle later as a fault where a grant was due. It can also show as a grant naming a different entry index. A priority fault shows only when two granting entries overlap, so the bench builds overlapping regions on purpose. It also makes regions that cover and apply but lack the needed permission, so that skipping such entries is seen at `rsp_idx`. A reference model is compared on every clock, so any divergence is flagged in the cycle it first becomes visible.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int PERM_W = 4;

  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_EXEC   = 2'd2,
    ACC_PORTAL = 2'd3
  } acc_kind_e;

  function automatic logic [PERM_W-1:0] perm_needed(input logic [1:0] kind);
    logic [PERM_W-1:0] m;
    m = '0;
    m[kind] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/prc_table.sv
module prc_table #(
  parameter int N      = 16,
  parameter int ADDR_W = 64,
  parameter int ID_W   = 16,
  parameter int PERM_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_wild,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [ID_W-1:0]   wr_owner,
  input  logic [ADDR_W-1:0] wr_lo,
  input  logic [ADDR_W-1:0] wr_hi,
  output logic [N-1:0]      ent_valid,
  output logic [N-1:0]      ent_wild,
  output logic [PERM_W-1:0] ent_perm  [N],
  output logic [ID_W-1:0]   ent_owner [N],
  output logic [ADDR_W-1:0] ent_lo    [N],
  output logic [ADDR_W-1:0] ent_hi    [N]
);
  logic [N-1:0] wr_sel;

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[i] <= 1'b0;
        ent_wild[i]  <= 1'b0;
        ent_perm[i]  <= '0;
        ent_owner[i] <= '0;
        ent_lo[i]    <= '0;
        ent_hi[i]    <= '0;
      end else if (wr_sel[i]) begin
        ent_valid[i] <= wr_valid;
        ent_wild[i]  <= wr_wild;
        ent_perm[i]  <= wr_perm;
        ent_owner[i] <= wr_owner;
        ent_lo[i]    <= wr_lo;
        ent_hi[i]    <= wr_hi;
      end
    end
  end
endmodule

// File: rtl/prc_match.sv
module prc_match
  import prc_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 64,
  parameter int ID_W   = 16
) (
  input  logic [N-1:0]      ent_valid,
  input  logic [N-1:0]      ent_wild,
  input  logic [PERM_W-1:0] ent_perm  [N],
  input  logic [ID_W-1:0]   ent_owner [N],
  input  logic [ADDR_W-1:0] ent_lo    [N],
  input  logic [ADDR_W-1:0] ent_hi    [N],
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   cur_turf,
  input  logic [ID_W-1:0]   cur_thread,
  output logic [N-1:0]      cover_vec,
  output logic [N-1:0]      owner_vec,
  output logic [N-1:0]      perm_vec,
  output logic [N-1:0]      hit_vec
);
  function automatic logic in_range(input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi,
                                    input logic [ADDR_W-1:0] a);
    return (a >= lo) && (a < hi);
  endfunction

  function automatic logic owner_applies(input logic wild,
                                         input logic [ID_W-1:0] owner,
                                         input logic [ID_W-1:0] turf,
                                         input logic [ID_W-1:0] thread);
    return wild ? (owner == thread) : (owner == turf);
  endfunction

  logic [PERM_W-1:0] need;
  assign need = perm_needed(req_kind);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign cover_vec[i] = in_range(ent_lo[i], ent_hi[i], req_addr);
    assign owner_vec[i] = owner_applies(ent_wild[i], ent_owner[i], cur_turf, cur_thread);
    assign perm_vec[i]  = |(ent_perm[i] & need);
    assign hit_vec[i]   = ent_valid[i] && cover_vec[i] && owner_vec[i] && perm_vec[i];
  end
endmodule

// File: rtl/prc_prio.sv
module prc_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_vec,
  output logic             any,
  output logic [IDX_W-1:0] first
);
  always_comb begin
    first = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) first = IDX_W'(i);
    end
  end
  assign any = |req_vec;
endmodule

// File: rtl/prot_region_chk.sv
module prot_region_chk
  import prc_pkg::*;
#(
  parameter int  NUM_REGIONS = 16,
  parameter int  ADDR_W      = 64,
  parameter int  ID_W        = 16,
  localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic              cfg_wild,
  input  logic [PERM_W-1:0] cfg_perm,
  input  logic [ID_W-1:0]   cfg_owner,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   cur_turf,
  input  logic [ID_W-1:0]   cur_thread,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_fault,
  output logic [IDX_W-1:0]  rsp_idx
);
  logic [NUM_REGIONS-1:0] valid_vec;
  logic [NUM_REGIONS-1:0] wild_vec;
  logic [PERM_W-1:0]      perm_arr  [NUM_REGIONS];
  logic [ID_W-1:0]        owner_arr [NUM_REGIONS];
  logic [ADDR_W-1:0]      lo_arr    [NUM_REGIONS];
  logic [ADDR_W-1:0]      hi_arr    [NUM_REGIONS];

  logic [NUM_REGIONS-1:0] cover_vec;
  logic [NUM_REGIONS-1:0] owner_vec;
  logic [NUM_REGIONS-1:0] perm_vec;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic                   hit_any;
  logic [IDX_W-1:0]       hit_idx;

  prc_table #(
    .N(NUM_REGIONS), .ADDR_W(ADDR_W), .ID_W(ID_W), .PERM_W(PERM_W), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid), .wr_wild(cfg_wild),
    .wr_perm(cfg_perm), .wr_owner(cfg_owner), .wr_lo(cfg_lo), .wr_hi(cfg_hi),
    .ent_valid(valid_vec), .ent_wild(wild_vec), .ent_perm(perm_arr),
    .ent_owner(owner_arr), .ent_lo(lo_arr), .ent_hi(hi_arr)
  );

  prc_match #(
    .N(NUM_REGIONS), .ADDR_W(ADDR_W), .ID_W(ID_W)
  ) u_match (
    .ent_valid(valid_vec), .ent_wild(wild_vec), .ent_perm(perm_arr),
    .ent_owner(owner_arr), .ent_lo(lo_arr), .ent_hi(hi_arr),
    .req_kind(req_kind), .req_addr(req_addr),
    .cur_turf(cur_turf), .cur_thread(cur_thread),
    .cover_vec(cover_vec), .owner_vec(owner_vec), .perm_vec(perm_vec),
    .hit_vec(hit_vec)
  );

  prc_prio #(
    .N(NUM_REGIONS), .IDX_W(IDX_W)
  ) u_prio (
    .req_vec(hit_vec), .any(hit_any), .first(hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && hit_any;
      rsp_fault <= req_valid && !hit_any;
      rsp_idx   <= (req_valid && hit_any) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/prc_chk.sv
module prc_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_idx,
  input logic             cfg_valid,
  input logic             req_valid,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     hit_vec,
  input logic             rsp_valid,
  input logic             rsp_grant,
  input logic             rsp_fault,
  input logic [IDX_W-1:0] rsp_idx
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> valid_vec == '0);

  assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid && (rsp_grant != rsp_fault));

  assert_fault_idx_zero_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_idx == '0);

  assert_grant_from_hit_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_grant == (|$past(hit_vec)));

  assert_lowest_index_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> ((($past(hit_vec) >> rsp_idx) & N'(1)) == N'(1)) &&
                  (($past(hit_vec) & ((N'(1) << rsp_idx) - N'(1))) == '0));

  assert_invalidate_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_valid) |=> !valid_vec[$past(cfg_idx)]);

  assert_invalid_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_vec & ~valid_vec) == '0);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_grant && !rsp_fault && rsp_idx == '0);
endmodule

bind prot_region_chk prc_chk #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_prc_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
  .req_valid(req_valid), .valid_vec(valid_vec), .hit_vec(hit_vec),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
  .rsp_idx(rsp_idx)
);

// File: tb/test_prot_region_chk.sv
`timescale 1ns/1ps
module test_prot_region_chk;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_wild = 1'b0;
  logic [3:0]  cfg_perm = '0;
  logic [15:0] cfg_owner = '0;
  logic [63:0] cfg_lo = '0;
  logic [63:0] cfg_hi = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [63:0] req_addr = '0;
  logic [15:0] cur_turf = '0;
  logic [15:0] cur_thread = '0;
  logic        rsp_valid, rsp_grant, rsp_fault;
  logic [3:0]  rsp_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference table
  bit          m_valid [NE];
  bit          m_wild  [NE];
  bit [3:0]    m_perm  [NE];
  bit [15:0]   m_owner [NE];
  bit [63:0]   m_lo    [NE];
  bit [63:0]   m_hi    [NE];

  always #2.5 clk = ~clk;

  prot_region_chk i_prot_region_chk (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_wild(cfg_wild),
    .cfg_perm(cfg_perm), .cfg_owner(cfg_owner), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .cur_turf(cur_turf), .cur_thread(cur_thread),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .rsp_idx(rsp_idx)
  );

  // Reference search: walk entries from 0 upward, stop at the first that grants.
  task automatic ref_eval(output bit g, output int idx);
    g = 0; idx = 0;
    for (int e = 0; e < NE; e++) begin
      bit who_ok, span_ok, kind_ok;
      who_ok  = m_wild[e] ? (m_owner[e] == cur_thread) : (m_owner[e] == cur_turf);
      span_ok = (req_addr >= m_lo[e]) && (req_addr < m_hi[e]);
      kind_ok = m_perm[e][req_kind];
      if (!g && m_valid[e] && who_ok && span_ok && kind_ok) begin
        g = 1; idx = e;
      end
    end
  endtask

  task automatic tick(input string tag);
    bit ev, eg;
    int ei;
    ev = req_valid && !rst;
    ref_eval(eg, ei);
    if (!ev) begin eg = 0; ei = 0; end
    if (rst) begin
      for (int e = 0; e < NE; e++) m_valid[e] = 0;
    end else if (cfg_we) begin
      m_valid[cfg_idx] = cfg_valid;  m_wild[cfg_idx] = cfg_wild;
      m_perm[cfg_idx]  = cfg_perm;   m_owner[cfg_idx] = cfg_owner;
      m_lo[cfg_idx]    = cfg_lo;     m_hi[cfg_idx] = cfg_hi;
    end
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== ev || rsp_grant !== (ev && eg) || rsp_fault !== (ev && !eg) ||
        rsp_idx !== 4'(ei)) begin
      n_bad++;
      $display("FAIL %s: actual v=%0b g=%0b f=%0b idx=%0d expected v=%0b g=%0b f=%0b idx=%0d",
               tag, rsp_valid, rsp_grant, rsp_fault, rsp_idx, ev, ev && eg, ev && !eg, ei);
    end
    req_valid = 1'b0;
    cfg_we    = 1'b0;
  endtask

  task automatic wr(input int idx, input bit v, input bit wild, input bit [3:0] perm,
                    input bit [15:0] owner, input bit [63:0] lo, input bit [63:0] hi);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v; cfg_wild = wild;
    cfg_perm = perm; cfg_owner = owner; cfg_lo = lo; cfg_hi = hi;
  endtask

  task automatic rq(input bit [1:0] kind, input bit [63:0] addr,
                    input bit [15:0] turf, input bit [15:0] thr);
    req_valid = 1'b1; req_kind = kind; req_addr = addr;
    cur_turf = turf; cur_thread = thr;
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_valid[e] = 0; m_wild[e] = 0; m_perm[e] = 0; m_owner[e] = 0; m_lo[e] = 0; m_hi[e] = 0;
    end
    // R10 reset state of outputs
    repeat (3) tick("R10 reset");
    rst = 1'b0;
    tick("R10 idle");
    // R1: empty table faults
    rq(0, 64'h1000, 5, 1); tick("R1 empty table");
    rq(2, 64'h0, 0, 0);    tick("R1 empty table");

    // R2: range [0x1000,0x2000) turf 5 read+write at entry 3
    wr(3, 1, 0, 4'b0011, 5, 64'h1000, 64'h2000); tick("R8 write");
    rq(0, 64'h1000, 5, 1); tick("R2 low bound");
    rq(0, 64'h1FFF, 5, 1); tick("R2 last byte");
    rq(0, 64'h2000, 5, 1); tick("R2 upper exclusive");
    rq(0, 64'h0FFF, 5, 1); tick("R2 below");
    wr(4, 1, 0, 4'b1111, 5, 64'h3000, 64'h3000); tick("R8 write");
    rq(0, 64'h3000, 5, 1); tick("R2 empty range");

    // R3: turf match only
    rq(1, 64'h1800, 6, 5); tick("R3 wrong turf");
    rq(1, 64'h1800, 5, 77); tick("R3 thread ignored");

    // R4: wildcard entry 5 owned by thread 9, execute only
    wr(5, 1, 1, 4'b0100, 9, 64'h8000, 64'h9000); tick("R8 write");
    rq(2, 64'h8800, 3, 9); tick("R4 thread match");
    rq(2, 64'h8800, 3, 8); tick("R4 thread mismatch");
    rq(2, 64'h8800, 9, 8); tick("R4 turf ignored");

    // R5: permission kinds
    rq(1, 64'h1100, 5, 0); tick("R5 write ok");
    rq(2, 64'h1100, 5, 0); tick("R5 exec denied");
    rq(3, 64'h1100, 5, 0); tick("R5 portal denied");
    wr(7, 1, 0, 4'b1000, 2, 64'hA000, 64'hB000); tick("R8 write");
    rq(3, 64'hA010, 2, 0); tick("R5 portal ok");
    rq(0, 64'hA010, 2, 0); tick("R5 read denied");

    // R6: overlapping regions, priority and skipping
    wr(1, 1, 0, 4'b0001, 5, 64'h1000, 64'h1800); tick("R8 write");
    wr(2, 1, 0, 4'b0010, 5, 64'h1000, 64'h1800); tick("R8 write");
    rq(1, 64'h1400, 5, 0); tick("R6 skip no-perm entry");
    rq(0, 64'h1400, 5, 0); tick("R6 lowest index");
    rq(0, 64'h1900, 5, 0); tick("R6 falls through to 3");

    // R8: same-cycle write sees old table
    wr(3, 0, 0, 4'b0011, 5, 64'h1000, 64'h2000);
    rq(0, 64'h1900, 5, 0); tick("R8 same-cycle old table");
    // R9: invalidated entry never grants
    rq(0, 64'h1900, 5, 0); tick("R9 invalid entry");
    wr(6, 0, 0, 4'b1111, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF); tick("R8 write");
    rq(1, 64'h55, 0, 0); tick("R9 invalid full range");

    // R10: idle cycles after activity
    tick("R10 idle"); tick("R10 idle");

    // mixed random traffic on a small address space
    for (int c = 0; c < 600; c++) begin
      if ($urandom_range(0, 9) < 3) begin
        bit [63:0] a, b;
        a = 64'($urandom_range(0, 63)); b = 64'($urandom_range(0, 63));
        wr($urandom_range(0, 15), $urandom_range(0, 5) != 0, 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 15)), 16'($urandom_range(0, 3)), a, b);
      end
      if ($urandom_range(0, 9) < 7)
        rq(2'($urandom_range(0, 3)), 64'($urandom_range(0, 63)),
           16'($urandom_range(0, 3)), 16'($urandom_range(0, 3)));
      tick("R6 random mix");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule